// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power state a small microcontroller is in and drives the enables that put that state into effect. There are three running states: full-speed active, medium-speed active and subactive. There are two sleeping states: standby and watch. A CPU sleep request moves the block from any running state into one of the two sleeping states. A qualified interrupt brings it back. Each state sets its own pattern of CPU and peripheral-group clock enables, its own main-oscillator enable and its own I/O port policy. Standby floats the port pins. Watch freezes them at their last values.

A wake is qualified only when the global mask is clear and at least one request has its own enable set. When the wake needs the main oscillator, the block restarts the oscillator first. It then stays in a settling state for 2^(6+2N) clock cycles, where N is the 3-bit settling selector, before it turns on the destination clocks. In the first cycle that the destination clocks are on, it gives a one-cycle pulse that starts interrupt handling. The selector and the medium-speed bit are captured when the wake is accepted.

Peripheral groups, by bit index of `grp_clk_en`:
- bit 0 is the always-on group: the watchdog, the asynchronous event counter and the comparators.
- bit 1 is the timekeeping group: the real-time clock and the interval timer.
- bit 2 holds all remaining peripherals.

`run_mode` encodes the current state as follows: 0 is full-speed active, 1 is medium-speed active, 2 is subactive and 3 is asleep or settling.

States and transitions:
- Reset enters ACT_HI.
- ACT_HI, ACT_MED and SUBACT go to STBY on a sleep request when `sel_standby`=1, and to WATCH on a sleep request when `sel_standby`=0.
- STBY goes to SETTLE_S on a qualified wake.
- WATCH goes to SUBACT on a qualified wake when `sel_lowspeed`=1, and to SETTLE_W on a qualified wake when `sel_lowspeed`=0.
- SETTLE_S and SETTLE_W go to ACT_MED or ACT_HI when the count runs out, depending on the captured medium-speed bit.
- Reset from any state returns to ACT_HI.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is asserted and right after it, the outputs read as follows: `run_mode`=0, `cpu_clk_en`=1, `grp_clk_en`=3'b111, `osc_en`=1, `io_hiz`=0, `io_hold`=0, `irq_start`=0.
- R2: A sleep request in a running state with `sel_standby`=1 enters standby at the next edge. Standby gives `run_mode`=3, `osc_en`=0, `cpu_clk_en`=0, `grp_clk_en`=3'b001, `io_hiz`=1 and `io_hold`=0.
- R3: A sleep request in a running state with `sel_standby`=0 enters watch at the next edge. Watch gives `run_mode`=3, `osc_en`=0, `cpu_clk_en`=0, `grp_clk_en`=3'b011, `io_hold`=1 and `io_hiz`=0.
- R4: While asleep, a request that is masked by `irq_mask`=1, or whose `irq_en` bit is 0, changes no output.
- R5: A qualified wake that needs the main oscillator sets `osc_en`=1 at the next edge. The CPU and peripheral clock enables, `run_mode` and the I/O policy keep their sleeping values for exactly 2^(6+2N) cycles, where N is `settle_sel`.
- R6: Leaving standby enters medium-speed active when `sel_medspeed` was 1 at the wake edge, and full-speed active otherwise. Later changes to `sel_medspeed` do not affect the result.
- R7: A qualified wake from watch with `sel_lowspeed`=1 enters subactive at the next edge with no settling delay. Subactive gives `run_mode`=2, `cpu_clk_en`=1, `grp_clk_en`=3'b111 and `osc_en`=0. With `sel_lowspeed`=0, the wake goes through settling to active, with the mode picked as in R6.
- R8: `irq_start` is a single-cycle pulse. It is 1 only in the first cycle that the destination state's clocks are on.
- R9: Reset while asleep or settling restarts the oscillator and returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | CPU sleep request, one cycle |
| sel_standby | input | 1 | 1: sleep enters standby; 0: sleep enters watch |
| sel_lowspeed | input | 1 | Watch exit to subactive when 1 |
| sel_medspeed | input | 1 | Active exit at medium speed when 1 |
| settle_sel | input | 3 | Settling length selector N |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks every wake |
| irq_req | input | NIRQ | Per-source interrupt requests |
| irq_en | input | NIRQ | Per-source interrupt enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| grp_clk_en | output | 3 | Peripheral group clock enables |
| osc_en | output | 1 | Main oscillator enable |
| io_hiz | output | 1 | Float all port outputs |
| io_hold | output | 1 | Freeze port outputs |
| irq_start | output | 1 | Start-interrupt-handling strobe |
| run_mode | output | 2 | Current mode code |

## Verification
The bench hits the settling window at its last cycle and at the cycle after it. A counter that is off by one would turn the clocks on a cycle early or late. It flips `sel_medspeed` in the middle of settling, so a design that reads the bit live instead of capturing it would land in the wrong active speed. It offers masked and disabled requests while asleep; a qualification that leaks would wake the block. It also resets the block during sleep and during settling, where a stale captured destination or a stuck strobe would show up. Watch exits to subactive are mixed in as well, because there a design that wrongly applied the delay would miss the immediate strobe.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_ACT_HI,
        ST_ACT_MED,
        ST_SUBACT,
        ST_STBY,
        ST_WATCH,
        ST_SETTLE_S,
        ST_SETTLE_W
    } pwr_state_t;

    localparam int GRP_N    = 3;
    localparam int GRP_AON  = 0;
    localparam int GRP_TIME = 1;
    localparam int GRP_MAIN = 2;

    localparam logic [1:0] MODE_HI    = 2'd0;
    localparam logic [1:0] MODE_MED   = 2'd1;
    localparam logic [1:0] MODE_SUB   = 2'd2;
    localparam logic [1:0] MODE_SLEEP = 2'd3;

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
    parameter int NIRQ = 8
) (
    input  logic            irq_mask,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_en,
    output logic            wake
);

    logic [NIRQ-1:0] live;

    for (genvar i = 0; i < NIRQ; i++) begin : g_src
        assign live[i] = irq_req[i] & irq_en[i];
    end

    assign wake = ~irq_mask & (|live);

endmodule

// File: rtl/pwr_settle_cnt.sv
module pwr_settle_cnt #(
    parameter int BASE_LOG2 = 6,
    parameter int STEP_LOG2 = 2,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);

    localparam int MAX_LOG2 = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1);
    localparam int CNT_W    = MAX_LOG2 + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] span;

    always_comb begin
        span = '0;
        span[BASE_LOG2 + STEP_LOG2 * int'(sel)] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= span - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_seq_pkg::*;
#(
    parameter int NIRQ      = 8,
    parameter int BASE_LOG2 = 6,
    parameter int STEP_LOG2 = 2,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             sel_standby,
    input  logic             sel_lowspeed,
    input  logic             sel_medspeed,
    input  logic [SEL_W-1:0] settle_sel,
    input  logic             irq_mask,
    input  logic [NIRQ-1:0]  irq_req,
    input  logic [NIRQ-1:0]  irq_en,
    output logic             cpu_clk_en,
    output logic [GRP_N-1:0] grp_clk_en,
    output logic             osc_en,
    output logic             io_hiz,
    output logic             io_hold,
    output logic             irq_start,
    output logic [1:0]       run_mode
);

    pwr_state_t state_q, state_d;
    logic       dest_med_q, dest_med_d;
    logic       strobe_q, strobe_d;
    logic       wake, settle_load, settle_done;

    localparam logic [GRP_N-1:0] GRP_ALL   = '1;
    localparam logic [GRP_N-1:0] GRP_STBY  = GRP_N'(1) << GRP_AON;
    localparam logic [GRP_N-1:0] GRP_WATCH = GRP_STBY | (GRP_N'(1) << GRP_TIME);

    pwr_wake_qual #(.NIRQ(NIRQ)) u_qual (
        .irq_mask (irq_mask),
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .wake     (wake)
    );

    pwr_settle_cnt #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .SEL_W     (SEL_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (settle_load),
        .sel   (settle_sel),
        .done  (settle_done)
    );

    // next-state decision
    always_comb begin
        state_d     = state_q;
        dest_med_d  = dest_med_q;
        strobe_d    = 1'b0;
        settle_load = 1'b0;
        unique case (state_q)
            ST_ACT_HI, ST_ACT_MED, ST_SUBACT: begin
                if (sleep_req) begin
                    state_d = sel_standby ? ST_STBY : ST_WATCH;
                end
            end
            ST_STBY: begin
                if (wake) begin
                    state_d     = ST_SETTLE_S;
                    settle_load = 1'b1;
                    dest_med_d  = sel_medspeed;
                end
            end
            ST_WATCH: begin
                if (wake) begin
                    if (sel_lowspeed) begin
                        state_d  = ST_SUBACT;
                        strobe_d = 1'b1;
                    end else begin
                        state_d     = ST_SETTLE_W;
                        settle_load = 1'b1;
                        dest_med_d  = sel_medspeed;
                    end
                end
            end
            ST_SETTLE_S, ST_SETTLE_W: begin
                if (settle_done) begin
                    state_d  = dest_med_q ? ST_ACT_MED : ST_ACT_HI;
                    strobe_d = 1'b1;
                end
            end
            default: state_d = ST_ACT_HI;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_ACT_HI;
            dest_med_q <= 1'b0;
            strobe_q   <= 1'b0;
        end else begin
            state_q    <= state_d;
            dest_med_q <= dest_med_d;
            strobe_q   <= strobe_d;
        end
    end

    // outputs per state
    always_comb begin
        cpu_clk_en = 1'b0;
        grp_clk_en = '0;
        osc_en     = 1'b0;
        io_hiz     = 1'b0;
        io_hold    = 1'b0;
        run_mode   = MODE_SLEEP;
        unique case (state_q)
            ST_ACT_HI: begin
                cpu_clk_en = 1'b1;
                grp_clk_en = GRP_ALL;
                osc_en     = 1'b1;
                run_mode   = MODE_HI;
            end
            ST_ACT_MED: begin
                cpu_clk_en = 1'b1;
                grp_clk_en = GRP_ALL;
                osc_en     = 1'b1;
                run_mode   = MODE_MED;
            end
            ST_SUBACT: begin
                cpu_clk_en = 1'b1;
                grp_clk_en = GRP_ALL;
                run_mode   = MODE_SUB;
            end
            ST_STBY: begin
                grp_clk_en = GRP_STBY;
                io_hiz     = 1'b1;
            end
            ST_WATCH: begin
                grp_clk_en = GRP_WATCH;
                io_hold    = 1'b1;
            end
            ST_SETTLE_S: begin
                grp_clk_en = GRP_STBY;
                io_hiz     = 1'b1;
                osc_en     = 1'b1;
            end
            ST_SETTLE_W: begin
                grp_clk_en = GRP_WATCH;
                io_hold    = 1'b1;
                osc_en     = 1'b1;
            end
            default: begin
                grp_clk_en = GRP_STBY;
            end
        endcase
    end

    assign irq_start = strobe_q;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
    parameter int NIRQ = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sleep_req,
    input logic            sel_standby,
    input logic            irq_mask,
    input logic [NIRQ-1:0] irq_req,
    input logic [NIRQ-1:0] irq_en,
    input logic            cpu_clk_en,
    input logic [2:0]      grp_clk_en,
    input logic            osc_en,
    input logic            io_hiz,
    input logic            io_hold,
    input logic            irq_start,
    input logic [1:0]      run_mode
);

    logic running, asleep, qualified;
    assign running   = (run_mode != 2'd3);
    assign asleep    = (run_mode == 2'd3) && !osc_en;
    assign qualified = !irq_mask && ((irq_req & irq_en) != '0);

    // R2
    sleep_to_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && sleep_req && sel_standby |=> io_hiz && !osc_en && !cpu_clk_en && grp_clk_en == 3'b001);

    // R3
    sleep_to_watch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && sleep_req && !sel_standby |=> io_hold && !io_hiz && !osc_en && grp_clk_en == 3'b011);

    // R4
    no_spurious_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep && !qualified |=> asleep && $stable(io_hiz) && $stable(io_hold));

    // R5
    settle_clocks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == 2'd3) && osc_en |-> !cpu_clk_en && !grp_clk_en[2]);

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |=> !irq_start);

    // R8
    strobe_with_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |-> cpu_clk_en && running && $past(run_mode) == 2'd3);

    // R2
    io_policy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_hiz && io_hold));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.NIRQ(NIRQ)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .sel_standby (sel_standby),
    .irq_mask    (irq_mask),
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .cpu_clk_en  (cpu_clk_en),
    .grp_clk_en  (grp_clk_en),
    .osc_en      (osc_en),
    .io_hiz      (io_hiz),
    .io_hold     (io_hold),
    .irq_start   (irq_start),
    .run_mode    (run_mode)
);

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;

    localparam int NIRQ = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sleep_req = 1'b0;
    logic            sel_standby = 1'b0;
    logic            sel_lowspeed = 1'b0;
    logic            sel_medspeed = 1'b0;
    logic [2:0]      settle_sel = 3'd0;
    logic            irq_mask = 1'b1;
    logic [NIRQ-1:0] irq_req = '0;
    logic [NIRQ-1:0] irq_en = '0;
    logic            cpu_clk_en, osc_en, io_hiz, io_hold, irq_start;
    logic [2:0]      grp_clk_en;
    logic [1:0]      run_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwr_mode_seq #(.NIRQ(NIRQ)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .sel_standby  (sel_standby),
        .sel_lowspeed (sel_lowspeed),
        .sel_medspeed (sel_medspeed),
        .settle_sel   (settle_sel),
        .irq_mask     (irq_mask),
        .irq_req      (irq_req),
        .irq_en       (irq_en),
        .cpu_clk_en   (cpu_clk_en),
        .grp_clk_en   (grp_clk_en),
        .osc_en       (osc_en),
        .io_hiz       (io_hiz),
        .io_hold      (io_hold),
        .irq_start    (irq_start),
        .run_mode     (run_mode)
    );

    function automatic logic [9:0] pack_out(logic [1:0] m, logic c, logic [2:0] g,
                                            logic o, logic z, logic h, logic s);
        return {m, c, g, o, z, h, s};
    endfunction

    function automatic logic [9:0] exp_state(int code, logic s);
        case (code)
            0: return pack_out(2'd0, 1'b1, 3'b111, 1'b1, 1'b0, 1'b0, s);
            1: return pack_out(2'd1, 1'b1, 3'b111, 1'b1, 1'b0, 1'b0, s);
            2: return pack_out(2'd2, 1'b1, 3'b111, 1'b0, 1'b0, 1'b0, s);
            3: return pack_out(2'd3, 1'b0, 3'b001, 1'b0, 1'b1, 1'b0, 1'b0);
            4: return pack_out(2'd3, 1'b0, 3'b011, 1'b0, 1'b0, 1'b1, 1'b0);
            5: return pack_out(2'd3, 1'b0, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0);
            default: return pack_out(2'd3, 1'b0, 3'b011, 1'b1, 1'b0, 1'b1, 1'b0);
        endcase
    endfunction

    task automatic check(string tag, int code, logic s);
        logic [9:0] act, exp;
        act = pack_out(run_mode, cpu_clk_en, grp_clk_en, osc_en, io_hiz, io_hold, irq_start);
        exp = exp_state(code, s);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%b exp=%b (mode,cpu,grp,osc,hiz,hold,strobe)", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic go_sleep(logic stby);
        sel_standby = stby;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        if (stby) check("R2 standby entry", 3, 1'b0);
        else      check("R3 watch entry", 4, 1'b0);
    endtask

    task automatic bad_wakes(int sleep_code);
        for (int t = 0; t < 3; t++) begin
            int b = $urandom % NIRQ;
            irq_req = '0;
            irq_req[b] = 1'b1;
            irq_en = '1;
            irq_mask = 1'b1;
            if (t != 0) begin
                irq_mask = 1'b0;
                irq_en = ~irq_req;
            end
            step();
            check("R4 ignored request", sleep_code, 1'b0);
        end
        irq_req = '0;
        irq_mask = 1'b1;
    endtask

    // wake from the current sleep state; returns the running code reached
    task automatic wake_up(logic from_watch, logic ls, logic med, int n, output int dest);
        int b = $urandom % NIRQ;
        int span = 1 << (6 + 2 * n);
        sel_lowspeed = ls;
        sel_medspeed = med;
        settle_sel = 3'(n);
        irq_mask = 1'b0;
        irq_en = '0;
        irq_en[b] = 1'b1;
        irq_req = '0;
        irq_req[b] = 1'b1;
        step();
        irq_req = '0;
        irq_mask = 1'b1;
        if (from_watch && ls) begin
            dest = 2;
            check("R7 watch to subactive with strobe R8", 2, 1'b1);
        end else begin
            dest = med ? 1 : 0;
            check("R5 oscillator restarts", from_watch ? 6 : 5, 1'b0);
            sel_medspeed = ~med;
            for (int k = 0; k < span - 2; k++) step();
            check("R5 still settling before last cycle", from_watch ? 6 : 5, 1'b0);
            step();
            check("R5 still settling in last cycle", from_watch ? 6 : 5, 1'b0);
            step();
            check("R6 R7 destination active with strobe R8", dest, 1'b1);
        end
        step();
        check("R8 strobe single cycle", dest, 1'b0);
    endtask

    initial begin
        int cur;
        void'($urandom(32'd20240517));
        step();
        check("R1 reset held", 0, 1'b0);
        step();
        rst_n = 1'b1;
        step();
        check("R1 after reset", 0, 1'b0);

        // directed: standby, medium-speed exit, N=0
        go_sleep(1'b1);
        bad_wakes(3);
        wake_up(1'b0, 1'b0, 1'b1, 0, cur);
        // directed: watch to subactive, then watch to active N=1
        go_sleep(1'b0);
        bad_wakes(4);
        wake_up(1'b1, 1'b1, 1'b0, 0, cur);
        go_sleep(1'b0);
        wake_up(1'b1, 1'b0, 1'b0, 1, cur);

        // R9: reset while asleep
        go_sleep(1'b1);
        rst_n = 1'b0;
        #1;
        check("R9 reset in standby", 0, 1'b0);
        step();
        rst_n = 1'b1;
        step();
        check("R9 after release", 0, 1'b0);

        // R9: reset while settling
        go_sleep(1'b0);
        sel_lowspeed = 1'b0;
        sel_medspeed = 1'b1;
        settle_sel = 3'd2;
        irq_mask = 1'b0;
        irq_en = '1;
        irq_req = 8'h01;
        step();
        irq_req = '0;
        irq_mask = 1'b1;
        for (int k = 0; k < 20; k++) step();
        check("R9 settling before reset", 6, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R9 reset in settling", 0, 1'b0);
        step();
        rst_n = 1'b1;
        for (int k = 0; k < 300; k++) step();
        check("R9 no stale wake after reset", 0, 1'b0);

        // constrained random episodes
        for (int e = 0; e < 30; e++) begin
            logic stby = 1'($urandom % 2);
            logic ls = 1'($urandom % 2);
            logic med = 1'($urandom % 2);
            int n = $urandom % 3;
            go_sleep(stby);
            if ($urandom % 2 == 0) bad_wakes(stby ? 3 : 4);
            wake_up(!stby, ls, med, n, cur);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule